// File: doc/BRIEF.md
# Rename History Buffer with Rollback

This block keeps an ordered record of every destination-register rename that one thread performs. Each record holds four fields: the instruction's sequence number, the architectural register, the physical register that was newly assigned, and the physical register it displaced. Records enter at the young end of a circular array.

The buffer is consumed from both ends.
- **Squash (rollback):** on a squash, the block walks backwards from the young end. For each record younger than the squash point it restores the map table and returns the new register to the free list. It also sets the scoreboard entry when the register index lies outside the ordinary physical range.
- **Commit (retire):** on a commit, it walks forward from the old end. For each record up to the done sequence number it returns the superseded register to the free list.

The map table, free list and scoreboard sit outside this block. They are driven through simple valid/data write ports.

Rollback takes one record per cycle. A busy flag stays high for the whole walk, and pushes are refused while it is high or while the array is full. Retirement also takes one record per cycle. It keeps walking after the commit pulse has gone, until it reaches a record younger than the done number. It is suspended whenever a squash is signalled or a rollback is running.

Top module: `rename_history`

## Requirements
- R1: `pushReady` is low when the buffer holds `DEPTH` records or `rollBusy` is high. A push offered while `pushReady` is low is discarded and never appears later in a rollback or retirement.
- R2: In the cycle after `squashValid`, `rollBusy` is high. While it is high and the youngest record's sequence number is greater than the registered squash number, that record is removed in that cycle. The removal drives `mapWrValid` with `mapWrArch` = its architectural register and `mapWrPhys` = its previous register, and drives `freeValid` with `freePhys` = its new register.
- R3: During a rollback removal whose new register index is at or above `NUM_PHYS`, `sbSetValid` is high with `sbSetPhys` equal to that index. Otherwise `sbSetValid` stays low.
- R4: `rollBusy` falls after the first busy cycle in which the buffer is empty or the youngest record is not younger than the squash number. A rollback that removes k records therefore keeps `rollBusy` high for k+1 cycles. `pushReady` is low throughout.
- R5: A nonzero `commitSeq` frees, in the same cycle, the oldest record if its sequence number is at or below `commitSeq`, driving `freeValid` with its previous register. Retirement then continues at one record per cycle in later cycles, with `commitSeq` at zero, until the oldest record exceeds that done number.
- R6: A `commitSeq` of zero starts nothing. A commit finding the buffer empty, or finding the oldest record younger than the done number, frees nothing.
- R7: In a cycle with `squashValid` or `rollBusy` high, no retirement takes place, the commit offered in that cycle is dropped, and a retirement walk in progress is abandoned.
- R8: After reset the buffer is empty, `rollBusy` is low, `pushReady` is high, and `freeValid`, `mapWrValid` and `sbSetValid` are low. Records pushed before the reset are lost.
- R9: A push and a retirement in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pushValid | input | 1 | Offer a new rename record |
| pushSeq | input | SEQ_W | Sequence number of the record |
| pushArch | input | ARCH_W | Architectural register renamed |
| pushNewPhys | input | PHYS_W | Physical register newly assigned |
| pushPrevPhys | input | PHYS_W | Physical register previously mapped |
| pushReady | output | 1 | Record accepted this cycle when high |
| squashValid | input | 1 | Squash request |
| squashSeq | input | SEQ_W | Records with larger numbers are rolled back |
| commitSeq | input | SEQ_W | Done sequence number; zero means none |
| rollBusy | output | 1 | Rollback walk in progress |
| mapWrValid | output | 1 | Map-table restore strobe |
| mapWrArch | output | ARCH_W | Architectural register to restore |
| mapWrPhys | output | PHYS_W | Physical register to restore into the map |
| freeValid | output | 1 | Free-list return strobe |
| freePhys | output | PHYS_W | Physical register returned |
| sbSetValid | output | 1 | Scoreboard mark-ready strobe |
| sbSetPhys | output | PHYS_W | Register marked ready |

## Verification
The hardest situations to reach are the ones where a commit collides with a rollback. One is a commit pulse landing in the same cycle as a squash. Another is a commit arriving while a walk is still busy.

The stimulus table fills the buffer, offers one more push while full, and then squashes into the middle of it. The rollback order and contents then show both that the refused push never entered and that the out-of-range register drove the scoreboard.

Later rows stack commit pulses on a squash cycle and on busy cycles. The free port must then show only rollback traffic, or nothing. A multi-record commit proves that retirement keeps walking after its pulse has ended.

// File: rtl/rhb_pkg.sv
package rhb_pkg;
  // Per-cycle actions the control grants to the storage.
  typedef struct packed {
    logic push;      // append at young end
    logic popOld;    // retire oldest record
    logic popYoung;  // roll back youngest record
  } rhb_strobe_t;
endpackage

// File: rtl/rhb_ctrl.sv
module rhb_ctrl
  import rhb_pkg::*;
#(
  parameter int SEQ_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushValid,
  input  logic             squashValid,
  input  logic [SEQ_W-1:0] squashSeq,
  input  logic [SEQ_W-1:0] commitSeq,
  input  logic             empty,
  input  logic             full,
  input  logic [SEQ_W-1:0] oldestSeq,
  input  logic [SEQ_W-1:0] youngestSeq,
  output rhb_strobe_t      strb,
  output logic             pushReady,
  output logic             rollBusy
);

  logic [SEQ_W-1:0] squashTgtQ;
  logic [SEQ_W-1:0] commitTgtQ;
  logic             commitHeldQ;
  logic             busyQ;

  logic             commitNew;
  logic             commitLive;
  logic [SEQ_W-1:0] commitTgt;

  assign commitNew  = (commitSeq != '0);
  assign commitLive = commitNew || commitHeldQ;
  assign commitTgt  = commitNew ? commitSeq : commitTgtQ;

  assign rollBusy  = busyQ;
  assign pushReady = !full && !busyQ;

  always_comb begin
    strb          = '0;
    strb.push     = pushValid && pushReady;
    strb.popYoung = busyQ && !empty && (youngestSeq > squashTgtQ);
    strb.popOld   = !busyQ && !squashValid && commitLive && !empty &&
                    (oldestSeq <= commitTgt);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ       <= 1'b0;
      squashTgtQ  <= '0;
      commitHeldQ <= 1'b0;
      commitTgtQ  <= '0;
    end else begin
      if (squashValid) begin
        busyQ      <= 1'b1;
        squashTgtQ <= squashSeq;
      end else if (busyQ && !strb.popYoung) begin
        busyQ <= 1'b0;
      end
      commitHeldQ <= strb.popOld;
      if (strb.popOld) commitTgtQ <= commitTgt;
    end
  end

  // R2: a squash always opens a rollback walk next cycle
  p_squash_opens_walk_r2: assert property (@(posedge clk) disable iff (!rstN)
    squashValid |=> rollBusy);
  // R7: no retirement while a squash is signalled or a walk runs
  p_commit_blocked_r7: assert property (@(posedge clk) disable iff (!rstN)
    (squashValid || busyQ) |-> !strb.popOld);
  // R2: the two ends are never consumed together
  p_single_pop_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.popOld, strb.popYoung}));
  // R4: a walk ending leaves no removable young record behind
  p_walk_end_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyQ) |-> !$past(strb.popYoung));

endmodule

// File: rtl/rhb_store.sv
module rhb_store
  import rhb_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int SEQ_W    = 16,
  parameter int ARCH_W   = 5,
  parameter int PHYS_W   = 7,
  parameter int NUM_PHYS = 96
) (
  input  logic              clk,
  input  logic              rstN,
  input  rhb_strobe_t       strb,
  input  logic [SEQ_W-1:0]  pushSeq,
  input  logic [ARCH_W-1:0] pushArch,
  input  logic [PHYS_W-1:0] pushNewPhys,
  input  logic [PHYS_W-1:0] pushPrevPhys,
  output logic              empty,
  output logic              full,
  output logic [SEQ_W-1:0]  oldestSeq,
  output logic [SEQ_W-1:0]  youngestSeq,
  output logic              mapWrValid,
  output logic [ARCH_W-1:0] mapWrArch,
  output logic [PHYS_W-1:0] mapWrPhys,
  output logic              freeValid,
  output logic [PHYS_W-1:0] freePhys,
  output logic              sbSetValid,
  output logic [PHYS_W-1:0] sbSetPhys
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [SEQ_W-1:0]  seqMem  [DEPTH];
  logic [ARCH_W-1:0] archMem [DEPTH];
  logic [PHYS_W-1:0] newMem  [DEPTH];
  logic [PHYS_W-1:0] prevMem [DEPTH];

  logic [PTR_W-1:0] headQ, tailQ, youngIdx;
  logic [CNT_W-1:0] countQ;

  function automatic logic [PTR_W-1:0] ptrInc(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PTR_W-1:0] ptrDec(input logic [PTR_W-1:0] p);
    return (p == '0) ? PTR_LAST : p - 1'b1;
  endfunction

  assign empty    = (countQ == '0);
  assign full     = (countQ == CNT_MAX);
  assign youngIdx = ptrDec(tailQ);

  assign oldestSeq   = seqMem[headQ];
  assign youngestSeq = seqMem[youngIdx];

  // Per-slot write enables
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (strb.push && (tailQ == PTR_W'(i))) begin
        seqMem[i]  <= pushSeq;
        archMem[i] <= pushArch;
        newMem[i]  <= pushNewPhys;
        prevMem[i] <= pushPrevPhys;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headQ  <= '0;
      tailQ  <= '0;
      countQ <= '0;
    end else begin
      if (strb.popYoung)   tailQ <= youngIdx;
      else if (strb.push)  tailQ <= ptrInc(tailQ);
      if (strb.popOld)     headQ <= ptrInc(headQ);
      case ({strb.push, strb.popOld | strb.popYoung})
        2'b10:   countQ <= countQ + 1'b1;
        2'b01:   countQ <= countQ - 1'b1;
        default: countQ <= countQ;
      endcase
    end
  end

  // Output ports toward map table, free list and scoreboard
  always_comb begin
    mapWrValid = strb.popYoung;
    mapWrArch  = archMem[youngIdx];
    mapWrPhys  = prevMem[youngIdx];
    freeValid  = strb.popYoung || strb.popOld;
    freePhys   = strb.popYoung ? newMem[youngIdx] : prevMem[headQ];
    sbSetPhys  = newMem[youngIdx];
    sbSetValid = strb.popYoung && (32'(newMem[youngIdx]) >= NUM_PHYS);
  end

  // R1: the control never grants a push into a full array
  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |-> !full);
  // R1: occupancy never exceeds the depth
  p_count_bound_r1: assert property (@(posedge clk) disable iff (!rstN)
    countQ <= CNT_MAX);
  // R2: removals only from a non-empty array
  p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.popOld || strb.popYoung) |-> !empty);
  // R3: scoreboard marks only out-of-range registers and matches the freed one
  p_sb_match_r3: assert property (@(posedge clk) disable iff (!rstN)
    sbSetValid |-> (freeValid && freePhys == sbSetPhys && 32'(sbSetPhys) >= NUM_PHYS));

endmodule

// File: rtl/rename_history.sv
module rename_history
  import rhb_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int SEQ_W    = 16,
  parameter int ARCH_W   = 5,
  parameter int PHYS_W   = 7,
  parameter int NUM_PHYS = 96
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushValid,
  input  logic [SEQ_W-1:0]  pushSeq,
  input  logic [ARCH_W-1:0] pushArch,
  input  logic [PHYS_W-1:0] pushNewPhys,
  input  logic [PHYS_W-1:0] pushPrevPhys,
  output logic              pushReady,
  input  logic              squashValid,
  input  logic [SEQ_W-1:0]  squashSeq,
  input  logic [SEQ_W-1:0]  commitSeq,
  output logic              rollBusy,
  output logic              mapWrValid,
  output logic [ARCH_W-1:0] mapWrArch,
  output logic [PHYS_W-1:0] mapWrPhys,
  output logic              freeValid,
  output logic [PHYS_W-1:0] freePhys,
  output logic              sbSetValid,
  output logic [PHYS_W-1:0] sbSetPhys
);

  rhb_strobe_t      strb;
  logic             empty, full;
  logic [SEQ_W-1:0] oldestSeq, youngestSeq;

  rhb_ctrl #(.SEQ_W(SEQ_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .pushValid   (pushValid),
    .squashValid (squashValid),
    .squashSeq   (squashSeq),
    .commitSeq   (commitSeq),
    .empty       (empty),
    .full        (full),
    .oldestSeq   (oldestSeq),
    .youngestSeq (youngestSeq),
    .strb        (strb),
    .pushReady   (pushReady),
    .rollBusy    (rollBusy)
  );

  rhb_store #(
    .DEPTH(DEPTH), .SEQ_W(SEQ_W), .ARCH_W(ARCH_W),
    .PHYS_W(PHYS_W), .NUM_PHYS(NUM_PHYS)
  ) u_store (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .pushSeq      (pushSeq),
    .pushArch     (pushArch),
    .pushNewPhys  (pushNewPhys),
    .pushPrevPhys (pushPrevPhys),
    .empty        (empty),
    .full         (full),
    .oldestSeq    (oldestSeq),
    .youngestSeq  (youngestSeq),
    .mapWrValid   (mapWrValid),
    .mapWrArch    (mapWrArch),
    .mapWrPhys    (mapWrPhys),
    .freeValid    (freeValid),
    .freePhys     (freePhys),
    .sbSetValid   (sbSetValid),
    .sbSetPhys    (sbSetPhys)
  );

  // R2: every map restore is paired with a free of the same removal
  p_restore_frees_r2: assert property (@(posedge clk) disable iff (!rstN)
    mapWrValid |-> (freeValid && rollBusy));

endmodule

// File: tb/rename_history_bench.sv
module rename_history_bench;

  localparam int DEPTH = 4, SEQ_W = 8, ARCH_W = 5, PHYS_W = 7, NUM_PHYS = 96;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pushValid = 1'b0, squashValid = 1'b0;
  logic [SEQ_W-1:0] pushSeq = '0, squashSeq = '0, commitSeq = '0;
  logic [ARCH_W-1:0] pushArch = '0;
  logic [PHYS_W-1:0] pushNewPhys = '0, pushPrevPhys = '0;
  logic pushReady, rollBusy, mapWrValid, freeValid, sbSetValid;
  logic [ARCH_W-1:0] mapWrArch;
  logic [PHYS_W-1:0] mapWrPhys, freePhys, sbSetPhys;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  rename_history #(
    .DEPTH(DEPTH), .SEQ_W(SEQ_W), .ARCH_W(ARCH_W),
    .PHYS_W(PHYS_W), .NUM_PHYS(NUM_PHYS)
  ) u_rename_history (.*);

  typedef struct packed {
    logic       pv;
    logic       sq;
    logic [7:0] cseq;
    logic [7:0] seq;
    logic [4:0] arch;
    logic [6:0] np;
    logic [6:0] pp;
    logic       eFree;
    logic [6:0] eFreePhys;
    logic       eMap;
    logic [4:0] eMapArch;
    logic [6:0] eMapPhys;
    logic       eSb;
    logic       eBusy;
    logic       eReady;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 29;
  // pv sq cseq seq arch np pp | eFree eFP eMap eMA eMP eSb eBusy eReady req
  localparam vec_t VECS [NV] = '{
    '{1,0, 0, 5,1, 40,10, 0,  0, 0,0, 0, 0,0,1, 1}, // R1 push
    '{1,0, 0, 6,2, 41,11, 0,  0, 0,0, 0, 0,0,1, 1},
    '{1,0, 0, 7,3,100,12, 0,  0, 0,0, 0, 0,0,1, 1},
    '{1,0, 0, 8,4, 42,13, 0,  0, 0,0, 0, 0,0,1, 1},
    '{0,0, 0, 0,0,  0, 0, 0,  0, 0,0, 0, 0,0,0, 1}, // R1 full
    '{1,0, 0, 9,5, 50,20, 0,  0, 0,0, 0, 0,0,0, 1}, // R1 refused push
    '{0,1, 0, 6,0,  0, 0, 0,  0, 0,0, 0, 0,0,0, 2}, // R2 squash to 6
    '{0,0, 0, 0,0,  0, 0, 1, 42, 1,4,13, 0,1,0, 2}, // R2 seq8 undone
    '{0,0, 0, 0,0,  0, 0, 1,100, 1,3,12, 1,1,0, 3}, // R3 misc reg
    '{0,0, 0, 0,0,  0, 0, 0,  0, 0,0, 0, 0,1,0, 4}, // R4 last busy
    '{0,0, 5, 0,0,  0, 0, 1, 10, 0,0, 0, 0,0,1, 5}, // R5 commit 5
    '{0,0, 0, 0,0,  0, 0, 0,  0, 0,0, 0, 0,0,1, 5},
    '{0,0, 3, 0,0,  0, 0, 0,  0, 0,0, 0, 0,0,1, 6}, // R6 oldest younger
    '{0,1, 6,10,0,  0, 0, 0,  0, 0,0, 0, 0,0,1, 7}, // R7 commit with squash
    '{0,0, 0, 0,0,  0, 0, 0,  0, 0,0, 0, 0,1,0, 4}, // R4 zero-removal walk
    '{1,0, 6,20,5, 43,14, 1, 11, 0,0, 0, 0,0,1, 9}, // R9 push + retire
    '{0,0, 0, 0,0,  0, 0, 0,  0, 0,0, 0, 0,0,1, 5},
    '{0,0,20, 0,0,  0, 0, 1, 14, 0,0, 0, 0,0,1, 5},
    '{0,0,30, 0,0,  0, 0, 0,  0, 0,0, 0, 0,0,1, 6}, // R6 empty
    '{1,0, 0,30,6, 44,15, 0,  0, 0,0, 0, 0,0,1, 1},
    '{1,0, 0,31,7, 45,16, 0,  0, 0,0, 0, 0,0,1, 1},
    '{1,0, 0,32,8, 46,17, 0,  0, 0,0, 0, 0,0,1, 1},
    '{0,0,31, 0,0,  0, 0, 1, 15, 0,0, 0, 0,0,1, 5}, // R5 walk start
    '{0,0, 0, 0,0,  0, 0, 1, 16, 0,0, 0, 0,0,1, 5}, // R5 walk continues
    '{0,0, 0, 0,0,  0, 0, 0,  0, 0,0, 0, 0,0,1, 5}, // R5 walk stops
    '{0,1, 0,31,0,  0, 0, 0,  0, 0,0, 0, 0,0,1, 2},
    '{0,0,40, 0,0,  0, 0, 1, 46, 1,8,17, 0,1,0, 7}, // R7 commit while busy
    '{0,0,40, 0,0,  0, 0, 0,  0, 0,0, 0, 0,1,0, 7},
    '{0,0, 0, 0,0,  0, 0, 0,  0, 0,0, 0, 0,0,1, 4}
  };

  task automatic clearIn();
    pushValid = 0; squashValid = 0; commitSeq = '0;
  endtask

  task automatic checkIdle(input string tag);
    checks++;
    if (freeValid || mapWrValid || sbSetValid || rollBusy || !pushReady) begin
      errors++;
      $display("FAIL %s: free=%0b map=%0b sb=%0b busy=%0b ready=%0b expected 0 0 0 0 1",
               tag, freeValid, mapWrValid, sbSetValid, rollBusy, pushReady);
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2 checkIdle("R8 reset state");
    @(negedge clk); rstN = 1;

    foreach (VECS[i]) begin
      @(negedge clk);
      pushValid = VECS[i].pv; squashValid = VECS[i].sq; commitSeq = VECS[i].cseq;
      pushSeq = VECS[i].seq; squashSeq = VECS[i].seq; pushArch = VECS[i].arch;
      pushNewPhys = VECS[i].np; pushPrevPhys = VECS[i].pp;
      #2;
      checks++;
      if (freeValid !== VECS[i].eFree || (VECS[i].eFree && freePhys !== VECS[i].eFreePhys) ||
          mapWrValid !== VECS[i].eMap ||
          (VECS[i].eMap && (mapWrArch !== VECS[i].eMapArch || mapWrPhys !== VECS[i].eMapPhys)) ||
          sbSetValid !== VECS[i].eSb || (VECS[i].eSb && sbSetPhys !== VECS[i].eFreePhys) ||
          rollBusy !== VECS[i].eBusy || pushReady !== VECS[i].eReady) begin
        errors++;
        $display("FAIL R%0d row %0d: free=%0b/%0d map=%0b/%0d/%0d sb=%0b busy=%0b ready=%0b expected free=%0b/%0d map=%0b/%0d/%0d sb=%0b busy=%0b ready=%0b",
                 VECS[i].req, i, freeValid, freePhys, mapWrValid, mapWrArch, mapWrPhys,
                 sbSetValid, rollBusy, pushReady, VECS[i].eFree, VECS[i].eFreePhys,
                 VECS[i].eMap, VECS[i].eMapArch, VECS[i].eMapPhys, VECS[i].eSb,
                 VECS[i].eBusy, VECS[i].eReady);
      end
    end

    // R8: reset mid-run discards stored records
    @(negedge clk); clearIn();
    pushValid = 1; pushSeq = 50; pushArch = 9; pushNewPhys = 60; pushPrevPhys = 30;
    @(negedge clk); pushSeq = 51; pushNewPhys = 61; pushPrevPhys = 31;
    @(negedge clk); clearIn(); rstN = 0;
    #2 checkIdle("R8 reset asserted");
    @(negedge clk); rstN = 1;
    @(negedge clk); commitSeq = 8'd255;
    #2 checkIdle("R8 commit after reset frees nothing");
    @(negedge clk); clearIn(); squashValid = 1; squashSeq = 0;
    @(negedge clk); clearIn();
    #2 checks++;
    if (freeValid || mapWrValid || !rollBusy) begin
      errors++;
      $display("FAIL R8 rollback after reset: free=%0b map=%0b busy=%0b expected 0 0 1",
               freeValid, mapWrValid, rollBusy);
    end
    @(negedge clk);
    #2 checkIdle("R4 walk on empty buffer ends");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule